// File: doc/BRIEF.md
# Packed Memory Tag Store Unit

This unit serves three kinds of request against a tag memory: fetching an allocation tag, writing one tag, and writing the same tag over two adjacent granules. The tag memory is a byte-wide synchronous SRAM. Each byte packs the 4-bit tags of two neighbouring 16-byte granules, so a 32-byte window of address space shares one byte.

A request arrives with a valid/ready handshake. It carries an opcode, a 64-bit virtual address and a 64-bit register value. The unit first asks an external translation stub about each page the request touches. The stub answers combinationally whether that page faults and whether it has tag storage. The unit then runs the SRAM accesses the request needs, which may include a read-modify-write on one or two bytes. It returns a single-cycle response with a register value and a fault code.

The unit takes one request at a time. It keeps ready low until the last SRAM write has committed, so two nibble updates to the same byte can never overlap.

Top module: `tag_store_unit`

## Requirements
- R1: The tag byte for address A sits at SRAM index A[12:5]. A[4]=0 selects the low nibble [3:0] and A[4]=1 selects the high nibble [7:4].
- R2: Opcode 0 (load) returns the request value with bits [59:56] replaced by the addressed nibble and every other bit unchanged. A load never writes the SRAM. Opcode 3 behaves as a load.
- R3: A load on a page that has no tag storage returns tag 0 in bits [59:56] and makes no SRAM access.
- R4: Opcode 1 (store) and opcode 2 (paired store) with A[3:0] not zero respond with fault code 1 and write nothing. This takes precedence over a page fault.
- R5: A store writes the tag taken from bits [59:56] of the request value. It reads the byte and writes it back with only the selected nibble replaced.
- R6: A paired store with A[4]=0 makes one SRAM write of the tag in both nibbles and reads nothing.
- R7: A paired store with A[4]=1 puts the tag in the high nibble of byte A[12:5] and in the low nibble of the next byte. Each of these is a read-modify-write that keeps the other nibble.
- R8: A page fault from the stub gives fault code 2 and no SRAM write. The fault takes priority over missing tag storage. Fault code 0 means success.
- R9: A paired store with A[4]=1 and A[11:4] all ones checks the next page as well. A fault on either page suppresses both writes. A page without tag storage skips only its own byte.
- R10: Ready is high only when the unit is idle. Ready stays low from acceptance through the response. The response valid lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_op | input | 2 | 0 load, 1 store, 2 paired store, 3 load |
| req_addr | input | 64 | Virtual address |
| req_data | input | 64 | Destination (load) or source (store) register value |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 64 | Result register value |
| rsp_fault | output | 2 | 0 none, 1 misaligned, 2 page fault |
| xl_vpn | output | 52 | Page number being checked |
| xl_fault | input | 1 | Stub reports that the page faults |
| xl_tagged | input | 1 | Stub reports that the page has tag storage |
| mem_en | output | 1 | SRAM enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | 8 | SRAM byte index |
| mem_wdata | output | 8 | SRAM write data |
| mem_rdata | input | 8 | SRAM read data, one cycle after the read |

## Verification
A wrong nibble select or byte index shows up in the SRAM contents or the loaded tag as soon as the response pulse arrives, a few cycles after the request. A sequencer that forgets the second byte of an unaligned paired store, or writes after a fault, leaves a byte changed or unchanged where it should not be. That difference can be seen right after the response. A stale check result from the first page in a page-crossing store would pass a fault unnoticed or skip the wrong byte. Both show in the response code and the memory contents of that same transaction.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_PAIR  = 2'd2,
        OP_LOADX = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_ALIGN = 2'd1,
        FLT_PAGE  = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHK_A,
        S_CHK_B,
        S_RD,
        S_RMW,
        S_FULL,
        S_RESP
    } state_e;
endpackage

// File: rtl/tsu_addr_decode.sv
module tsu_addr_decode #(
    parameter int AW        = 64,
    parameter int MEM_AW    = 8,
    parameter int GRAN_LOG2 = 4,
    parameter int PAGE_LOG2 = 12,
    localparam int VPN_W    = AW - PAGE_LOG2
) (
    input  logic [AW-1:0]     addr,
    input  logic              second,
    output logic [MEM_AW-1:0] mem_idx,
    output logic              hi_nib,
    output logic              misalign,
    output logic              odd_gran,
    output logic              cross_page,
    output logic [VPN_W-1:0]  vpn
);
    // Two granules share one byte, so the index drops one more bit than the granule.
    assign mem_idx    = addr[GRAN_LOG2+1 +: MEM_AW] + {{(MEM_AW-1){1'b0}}, second};
    // The second byte of an odd paired store always takes its low nibble.
    assign hi_nib     = second ? 1'b0 : addr[GRAN_LOG2];
    assign misalign   = |addr[GRAN_LOG2-1:0];
    assign odd_gran   = addr[GRAN_LOG2];
    assign cross_page = &addr[PAGE_LOG2-1:GRAN_LOG2];
    assign vpn        = addr[AW-1:PAGE_LOG2];
endmodule

// File: rtl/tsu_nibble_merge.sv
module tsu_nibble_merge #(
    parameter int TAG_W = 4
) (
    input  logic [2*TAG_W-1:0] old_byte,
    input  logic [TAG_W-1:0]   tag,
    input  logic               hi,
    output logic [2*TAG_W-1:0] new_byte,
    output logic [TAG_W-1:0]   sel_tag
);
    assign new_byte = hi ? {tag, old_byte[TAG_W-1:0]} : {old_byte[2*TAG_W-1:TAG_W], tag};
    assign sel_tag  = hi ? old_byte[2*TAG_W-1:TAG_W] : old_byte[TAG_W-1:0];
endmodule

// File: rtl/tag_store_unit.sv
module tag_store_unit
    import tsu_pkg::*;
#(
    parameter int AW        = 64,
    parameter int DW        = 64,
    parameter int MEM_AW    = 8,
    parameter int GRAN_LOG2 = 4,
    parameter int PAGE_LOG2 = 12,
    parameter int TAG_LSB   = 56,
    localparam int TAG_W    = 4,
    localparam int VPN_W    = AW - PAGE_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_data,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_data,
    output logic [1:0]        rsp_fault,
    output logic [VPN_W-1:0]  xl_vpn,
    input  logic              xl_fault,
    input  logic              xl_tagged,
    output logic              mem_en,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    typedef struct packed {
        state_e          st;
        op_e             op;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   data;
        logic            tag_a;
        logic            tag_b;
        logic            second;
        fault_e          fault;
    } regs_t;

    regs_t r_q, r_d;

    logic [MEM_AW-1:0] idx;
    logic              hi_nib, misalign, odd_gran, cross_page;
    logic [VPN_W-1:0]  vpn;
    logic [7:0]        merged;
    logic [TAG_W-1:0]  rd_tag;
    logic [TAG_W-1:0]  st_tag;
    logic              is_load;

    tsu_addr_decode #(
        .AW(AW), .MEM_AW(MEM_AW), .GRAN_LOG2(GRAN_LOG2), .PAGE_LOG2(PAGE_LOG2)
    ) dec_i (
        .addr(r_q.addr), .second(r_q.second), .mem_idx(idx), .hi_nib(hi_nib),
        .misalign(misalign), .odd_gran(odd_gran), .cross_page(cross_page), .vpn(vpn)
    );

    assign st_tag  = r_q.data[TAG_LSB +: TAG_W];
    assign is_load = (r_q.op == OP_LOAD) || (r_q.op == OP_LOADX);

    tsu_nibble_merge #(.TAG_W(TAG_W)) mrg_i (
        .old_byte(mem_rdata), .tag(st_tag), .hi(hi_nib),
        .new_byte(merged), .sel_tag(rd_tag)
    );

    logic ta_n, tb_n;
    state_e go_st;
    logic   go_second;

    always_comb begin
        r_d       = r_q;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = idx;
        mem_wdata = 8'h00;
        xl_vpn    = (r_q.st == S_CHK_B) ? vpn + VPN_W'(1) : vpn;

        // Check outcome for each granule, then where the sequence goes next.
        ta_n = (r_q.st == S_CHK_B) ? r_q.tag_a : xl_tagged;
        tb_n = xl_tagged;
        go_second = 1'b0;
        if (r_q.op == OP_PAIR && !odd_gran) begin
            go_st = ta_n ? S_FULL : S_RESP;
        end else if (r_q.op == OP_PAIR) begin
            go_st     = (ta_n || tb_n) ? S_RD : S_RESP;
            go_second = !ta_n;
        end else begin
            go_st = ta_n ? S_RD : S_RESP;
        end

        case (r_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    r_d.op     = op_e'(req_op);
                    r_d.addr   = req_addr;
                    r_d.data   = req_data;
                    if (req_op == OP_LOAD || req_op == OP_LOADX)
                        r_d.data[TAG_LSB +: TAG_W] = '0;
                    r_d.second = 1'b0;
                    r_d.fault  = FLT_NONE;
                    r_d.st     = S_CHK_A;
                end
            end
            S_CHK_A: begin
                if (!is_load && misalign) begin
                    r_d.fault = FLT_ALIGN;
                    r_d.st    = S_RESP;
                end else if (xl_fault) begin
                    r_d.fault = FLT_PAGE;
                    r_d.st    = S_RESP;
                end else begin
                    r_d.tag_a = ta_n;
                    r_d.tag_b = tb_n;
                    if (r_q.op == OP_PAIR && odd_gran && cross_page) begin
                        r_d.st = S_CHK_B;
                    end else begin
                        r_d.st     = go_st;
                        r_d.second = go_second;
                    end
                end
            end
            S_CHK_B: begin
                if (xl_fault) begin
                    r_d.fault = FLT_PAGE;
                    r_d.st    = S_RESP;
                end else begin
                    r_d.tag_b  = tb_n;
                    r_d.st     = go_st;
                    r_d.second = go_second;
                end
            end
            S_RD: begin
                mem_en = 1'b1;
                r_d.st = S_RMW;
            end
            S_RMW: begin
                if (is_load) begin
                    r_d.data[TAG_LSB +: TAG_W] = rd_tag;
                    r_d.st = S_RESP;
                end else begin
                    mem_en    = 1'b1;
                    mem_we    = 1'b1;
                    mem_wdata = merged;
                    if (r_q.op == OP_PAIR && odd_gran && !r_q.second && r_q.tag_b) begin
                        r_d.second = 1'b1;
                        r_d.st     = S_RD;
                    end else begin
                        r_d.st = S_RESP;
                    end
                end
            end
            S_FULL: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {st_tag, st_tag};
                r_d.st    = S_RESP;
            end
            S_RESP: r_d.st = S_IDLE;
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, op: OP_LOAD, fault: FLT_NONE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == S_IDLE);
    assign rsp_valid = (r_q.st == S_RESP);
    assign rsp_data  = r_q.data;
    assign rsp_fault = r_q.fault;
endmodule

// File: rtl/tag_store_unit_chk.sv
module tag_store_unit_chk #(
    parameter int AW      = 64,
    parameter int DW      = 64,
    parameter int TAG_LSB = 56
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [1:0]    req_op,
    input logic [AW-1:0] req_addr,
    input logic [DW-1:0] req_data,
    input logic          rsp_valid,
    input logic [DW-1:0] rsp_data,
    input logic [1:0]    rsp_fault,
    input logic          mem_en,
    input logic          mem_we
);
    logic [1:0]    c_op;
    logic [AW-1:0] c_addr;
    logic [DW-1:0] c_data;
    logic [3:0]    c_wr, c_rd;
    logic [DW-1:0] keep_mask;

    assign keep_mask = ~({{(DW-4){1'b0}}, 4'hF} << TAG_LSB);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_op <= '0; c_addr <= '0; c_data <= '0; c_wr <= '0; c_rd <= '0;
        end else if (req_valid && req_ready) begin
            c_op <= req_op; c_addr <= req_addr; c_data <= req_data;
            c_wr <= '0; c_rd <= '0;
        end else begin
            if (mem_en && mem_we && c_wr != 4'hF) c_wr <= c_wr + 4'd1;
            if (mem_en && !mem_we && c_rd != 4'hF) c_rd <= c_rd + 4'd1;
        end
    end

    AST_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> !req_ready); // R10
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R10
    AST_RSP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R10
    AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && c_op[0] == c_op[1]) |-> c_wr == 4'd0); // R2
    AST_LOAD_KEEP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && c_op[0] == c_op[1]) |-> (rsp_data & keep_mask) == (c_data & keep_mask)); // R2
    AST_MISALIGN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && c_op[0] != c_op[1] && c_addr[3:0] != 4'd0) |-> rsp_fault == 2'd1); // R4
    AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> c_wr == 4'd0); // R8
    AST_FULL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && c_op == 2'd2 && !c_addr[4]) |-> (c_rd == 4'd0 && c_wr <= 4'd1)); // R6
    AST_PAIR_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && c_op == 2'd2 && c_addr[4]) |-> (c_wr <= 4'd2 && c_rd == c_wr)); // R7
endmodule

bind tag_store_unit tag_store_unit_chk #(.AW(AW), .DW(DW), .TAG_LSB(TAG_LSB)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fault(rsp_fault),
    .mem_en(mem_en), .mem_we(mem_we)
);

// File: tb/tag_store_unit_tb_top.sv
`timescale 1ns/1ps
module tag_store_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [63:0] req_addr = '0;
    logic [63:0] req_data = '0;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic [1:0]  rsp_fault;
    logic [51:0] xl_vpn;
    logic        xl_fault, xl_tagged;
    logic        mem_en, mem_we;
    logic [7:0]  mem_addr, mem_wdata, mem_rdata;

    logic [7:0]  mem [256];
    int          rd_cnt, wr_cnt;
    logic        flt_on = 1'b0, notag_on = 1'b0;
    logic [51:0] flt_vpn = '0, notag_vpn = '0;

    int n_tests = 0, n_fail = 0;
    logic [63:0] got_data;
    logic [1:0]  got_fault;

    always #4 clk = ~clk;

    assign xl_fault  = flt_on && (xl_vpn == flt_vpn);
    assign xl_tagged = !(notag_on && (xl_vpn == notag_vpn));

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin mem[mem_addr] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
            else begin mem_rdata <= mem[mem_addr]; rd_cnt <= rd_cnt + 1; end
        end
    end

    tag_store_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fault(rsp_fault),
        .xl_vpn(xl_vpn), .xl_fault(xl_fault), .xl_tagged(xl_tagged),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] op, input logic [63:0] a, input logic [63:0] d);
        int w = 0;
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0;
        req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R10 ready low after accept", 64'(req_ready), 64'd0);
        while (!rsp_valid && w < 50) begin @(negedge clk); w++; end
        got_data = rsp_data; got_fault = rsp_fault;
        chk(rsp_valid, "R10 response arrives", 64'(rsp_valid), 64'd1);
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R10 one-cycle response", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_reset;
        chk(req_ready && !rsp_valid && !mem_en, "R10 reset state",
            {61'd0, req_ready, rsp_valid, mem_en}, 64'd4);
    endtask

    task automatic t_load;
        mem[8'h12] = 8'hA5;
        run(2'd0, 64'h0000_0000_0000_0240, 64'h1234_5678_9ABC_DEF0);
        chk(got_data == 64'h1534_5678_9ABC_DEF0 && got_fault == 0, "R1 R2 load low nibble",
            got_data, 64'h1534_5678_9ABC_DEF0);
        chk(wr_cnt == 0, "R2 load no write", 64'(wr_cnt), 0);
        run(2'd3, 64'h0000_0000_0000_0257, 64'hFFFF_FFFF_FFFF_FFFF);
        chk(got_data == 64'hFAFF_FFFF_FFFF_FFFF, "R1 R2 load high nibble via op3",
            got_data, 64'hFAFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_load_notag;
        notag_on = 1; notag_vpn = 52'd0;
        run(2'd0, 64'h0000_0000_0000_0240, 64'h0F00_0000_0000_0001);
        chk(got_data == 64'h0000_0000_0000_0001 && rd_cnt == 0, "R3 untagged load tag 0",
            got_data, 64'h1);
        notag_on = 0;
    endtask

    task automatic t_store;
        mem[8'h20] = 8'hA5;
        run(2'd1, 64'h0000_0000_0000_0400, 64'h0300_0000_0000_0000);
        chk(mem[8'h20] == 8'hA3 && got_fault == 0, "R5 store low nibble", 64'(mem[8'h20]), 64'hA3);
        run(2'd1, 64'h0000_0000_0000_0410, 64'h0C00_0000_0000_0000);
        chk(mem[8'h20] == 8'hC3, "R5 store high nibble keeps low", 64'(mem[8'h20]), 64'hC3);
    endtask

    task automatic t_misalign;
        mem[8'h21] = 8'h66;
        run(2'd1, 64'h0000_0000_0000_0428, 64'h0100_0000_0000_0000);
        chk(got_fault == 1 && mem[8'h21] == 8'h66 && wr_cnt == 0, "R4 misaligned store",
            64'(got_fault), 64'd1);
        flt_on = 1; flt_vpn = 52'd0;
        run(2'd2, 64'h0000_0000_0000_0424, 64'h0100_0000_0000_0000);
        chk(got_fault == 1, "R4 align beats page fault", 64'(got_fault), 64'd1);
        flt_on = 0;
    endtask

    task automatic t_pair_full;
        mem[8'h30] = 8'h12;
        run(2'd2, 64'h0000_0000_0000_0600, 64'h0700_0000_0000_0000);
        chk(mem[8'h30] == 8'h77 && rd_cnt == 0 && wr_cnt == 1, "R6 aligned pair one write",
            64'(mem[8'h30]), 64'h77);
    endtask

    task automatic t_pair_odd;
        mem[8'h40] = 8'h12; mem[8'h41] = 8'h34;
        run(2'd2, 64'h0000_0000_0000_0810, 64'h0900_0000_0000_0000);
        chk(mem[8'h40] == 8'h92, "R7 odd pair first byte high", 64'(mem[8'h40]), 64'h92);
        chk(mem[8'h41] == 8'h39, "R7 odd pair next byte low", 64'(mem[8'h41]), 64'h39);
    endtask

    task automatic t_faults;
        mem[8'h50] = 8'h11;
        flt_on = 1; flt_vpn = 52'd0;
        run(2'd0, 64'h0000_0000_0000_0A00, 64'h0);
        chk(got_fault == 2, "R8 load page fault", 64'(got_fault), 64'd2);
        notag_on = 1; notag_vpn = 52'd0;
        run(2'd1, 64'h0000_0000_0000_0A00, 64'h0500_0000_0000_0000);
        chk(got_fault == 2 && mem[8'h50] == 8'h11, "R8 fault beats untagged",
            64'(got_fault), 64'd2);
        flt_on = 0; notag_on = 0;
    endtask

    task automatic t_cross;
        mem[8'h7F] = 8'hAB; mem[8'h80] = 8'hCD;
        flt_on = 1; flt_vpn = 52'd1;
        run(2'd2, 64'h0000_0000_0000_0FF0, 64'h0400_0000_0000_0000);
        chk(got_fault == 2 && mem[8'h7F] == 8'hAB && mem[8'h80] == 8'hCD,
            "R9 second page fault blocks both", 64'(got_fault), 64'd2);
        flt_on = 0; notag_on = 1; notag_vpn = 52'd1;
        run(2'd2, 64'h0000_0000_0000_0FF0, 64'h0400_0000_0000_0000);
        chk(got_fault == 0 && mem[8'h7F] == 8'h4B && mem[8'h80] == 8'hCD,
            "R9 untagged second page skipped", {48'd0, mem[8'h7F], mem[8'h80]}, 64'h4BCD);
        notag_vpn = 52'd0;
        run(2'd2, 64'h0000_0000_0000_0FF0, 64'h0600_0000_0000_0000);
        chk(mem[8'h7F] == 8'h4B && mem[8'h80] == 8'hC6,
            "R9 untagged first page skipped", {48'd0, mem[8'h7F], mem[8'h80]}, 64'h4BC6);
        notag_on = 0;
    endtask

    initial begin
        int cyc = 0;
        fork
            begin
                for (int i = 0; i < 256; i++) mem[i] = 8'h00;
                rd_cnt = 0; wr_cnt = 0;
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_load();
                t_load_notag();
                t_store();
                t_misalign();
                t_pair_full();
                t_pair_odd();
                t_faults();
                t_cross();
            end
            begin
                while (cyc < 100000) begin @(posedge clk); cyc++; end
                n_tests++; n_fail++;
                $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule